// File: doc/BRIEF.md
# Half-Duplex SPI Transfer Engine

This block is an SPI master that carries out one complete half-duplex transaction each time it is started. Inside a single chip-select window it first shifts out a string of command and address bytes taken from a byte stream with a valid/ready handshake, and it throws away whatever the peripheral returns during that time. It then clocks in a requested number of response bytes while driving zero fill bytes on MOSI. Each response byte appears on a receive stream with a one-cycle valid strobe. A done pulse marks the end of the transaction.

The serial clock rate follows from a system clock frequency input and a fixed 8 MHz target. The quotient of the input frequency by twice the target, less one when it is non-zero, is saturated to a 7-bit divide field. Each SCLK half period lasts that field plus one system clock cycles. Frames are 8 bits in SPI mode 0. The engine has an enable input. While the enable is low, chip select stays released and start requests are refused.

Top module: `spi_xfer_engine`

## Requirements
- R1: The SCLK half period, in system clock cycles, equals D+1. D is q-1 when q is at least 1 and 0 otherwise, with q = floor(sys_hz / 16,000,000), and D is saturated at 127.
- R2: cs_n is high in idle. It goes low after a start is accepted and goes high again after the last byte. done is high for exactly one cycle, and that cycle is the first one in which cs_n is high again.
- R3: In the write phase each byte is taken through one tx_valid/tx_ready handshake and sent MSB first. The bytes sent in that phase are the tx_len stream bytes, in order.
- R4: In the read phase each of the rx_len byte slots sends 0x00 on MOSI. The byte sampled from MISO in a slot appears on rx_data with rx_valid high for one cycle.
- R5: Transfers use SPI mode 0. SCLK idles low, MISO is sampled on the rising edge, and MOSI holds its value while SCLK is high.
- R6: MOSI is 0 whenever no byte is being shifted, and in particular whenever cs_n is high.
- R7: A zero tx_len skips the write phase and a zero rx_len skips the read phase. With both at zero, cs_n still falls once and rises once, and done pulses.
- R8: A start pulse during a transaction is ignored. No second chip-select window follows.
- R9: While enable is low, cs_n is high from the next cycle on, any transfer in progress is abandoned, and start has no effect.
- R10: Bytes received during the write phase, and any data held from earlier, never appear on the receive stream. rx_valid is only asserted for read-phase slots, with cs_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Engine enable; low forces chip select high and aborts |
| start | input | 1 | One-cycle request to begin a transaction |
| tx_len | input | 8 | Number of bytes in the write phase |
| rx_len | input | 8 | Number of bytes in the read phase |
| sys_hz | input | 32 | System clock frequency in Hz |
| tx_data | input | 8 | Write-phase byte stream data |
| tx_valid | input | 1 | Write-phase byte available |
| tx_ready | output | 1 | Engine takes tx_data at this clock edge when tx_valid is high |
| miso | input | 1 | Serial data from the peripheral |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 1 | Active-low chip select |
| rx_data | output | 8 | Read-phase byte |
| rx_valid | output | 1 | rx_data is valid this cycle |
| done | output | 1 | One-cycle pulse at the end of a transaction |

## Verification
A change on sys_hz reaches the divide register one cycle later. The bench therefore waits several cycles after changing it and only then starts a transaction, and it measures the high time of SCLK by counting system clock cycles sampled on the falling edge. The first SCLK rising edge comes D+1 cycles after a byte is loaded. A received byte shows up on rx_valid one cycle after the shifter's eighth falling edge, and done arrives two cycles after the last byte completes, in the cycle where cs_n is sampled high again. Results are not tied to fixed cycle numbers: a scoreboard queue holds the expected MOSI bytes and receive bytes, a monitor pops them as the design produces them, and at each done pulse the bench checks that every queue is empty and that exactly one chip-select window has occurred.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_TX_REQ,
    ST_TX_RUN,
    ST_RX_GO,
    ST_RX_RUN,
    ST_FINISH
  } xfer_state_t;
endpackage

// File: rtl/spi_rate_calc.sv
module spi_rate_calc #(
  parameter int SYS_W     = 32,
  parameter int DIV_W     = 7,
  parameter int TARGET_HZ = 8_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SYS_W-1:0] sys_hz,
  output logic [DIV_W-1:0] div
);
  localparam logic [SYS_W-1:0] DIVISOR = SYS_W'(2 * TARGET_HZ);
  localparam logic [SYS_W-1:0] DIV_MAX = SYS_W'((1 << DIV_W) - 1);

  logic [SYS_W-1:0] quot;
  logic [SYS_W-1:0] minus_one;
  logic [DIV_W-1:0] div_nxt;
  logic [DIV_W-1:0] div_q;

  always_comb begin
    quot      = sys_hz / DIVISOR;
    minus_one = (quot != '0) ? quot - SYS_W'(1) : '0;
    div_nxt   = (minus_one > DIV_MAX) ? DIV_MAX[DIV_W-1:0] : minus_one[DIV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_nxt;
  end

  assign div = div_q;
endmodule

// File: rtl/spi_half_tick.sv
module spi_half_tick #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_nxt;
  logic             wrap;

  always_comb begin
    wrap = (cnt_q == div);
    if (!run)      cnt_nxt = '0;
    else if (wrap) cnt_nxt = '0;
    else           cnt_nxt = cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign tick = run && wrap;

  // R1
  tick_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(div)) |-> (cnt_q <= div));
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            abort,
  input  logic [BITS-1:0] load_byte,
  input  logic            tick,
  input  logic            miso,
  output logic            active,
  output logic            sclk,
  output logic            mosi,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte
);
  localparam int HALVES = 2 * BITS;
  localparam int EC_W   = $clog2(HALVES);
  localparam logic [EC_W-1:0] LAST_HALF = EC_W'(HALVES - 1);

  logic            active_q, active_nxt;
  logic            sclk_q, sclk_nxt;
  logic [BITS-1:0] tx_sh_q, tx_sh_nxt;
  logic [BITS-1:0] rx_sh_q, rx_sh_nxt;
  logic [EC_W-1:0] half_q, half_nxt;
  logic            done_q, done_nxt;

  always_comb begin
    active_nxt = active_q;
    sclk_nxt   = sclk_q;
    tx_sh_nxt  = tx_sh_q;
    rx_sh_nxt  = rx_sh_q;
    half_nxt   = half_q;
    done_nxt   = 1'b0;
    if (abort) begin
      active_nxt = 1'b0;
      sclk_nxt   = 1'b0;
      half_nxt   = '0;
    end else if (!active_q) begin
      if (load) begin
        active_nxt = 1'b1;
        sclk_nxt   = 1'b0;
        tx_sh_nxt  = load_byte;
        half_nxt   = '0;
      end
    end else if (tick) begin
      half_nxt = half_q + EC_W'(1);
      if (!sclk_q) begin
        sclk_nxt  = 1'b1;
        rx_sh_nxt = {rx_sh_q[BITS-2:0], miso};
      end else begin
        sclk_nxt  = 1'b0;
        tx_sh_nxt = {tx_sh_q[BITS-2:0], 1'b0};
        if (half_q == LAST_HALF) begin
          active_nxt = 1'b0;
          done_nxt   = 1'b1;
          half_nxt   = '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      half_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_nxt;
      sclk_q   <= sclk_nxt;
      tx_sh_q  <= tx_sh_nxt;
      rx_sh_q  <= rx_sh_nxt;
      half_q   <= half_nxt;
      done_q   <= done_nxt;
    end
  end

  assign active    = active_q;
  assign sclk      = sclk_q;
  assign mosi      = active_q & tx_sh_q[BITS-1];
  assign byte_done = done_q;
  assign rx_byte   = rx_sh_q;

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_q && $past(sclk_q)) |-> $stable(mosi));

  // R5
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !sclk_q);
endmodule

// File: rtl/spi_xfer_ctrl.sv
module spi_xfer_ctrl
  import spi_xfer_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int BITS  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [BITS-1:0]  tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic             byte_done,
  input  logic [BITS-1:0]  rx_byte,
  output logic             sh_load,
  output logic [BITS-1:0]  sh_byte,
  output logic             sh_abort,
  output logic             cs_n,
  output logic [BITS-1:0]  rx_data,
  output logic             rx_valid,
  output logic             done
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  xfer_state_t      state_q, state_nxt;
  logic [LEN_W-1:0] tx_left_q, tx_left_nxt;
  logic [LEN_W-1:0] rx_left_q, rx_left_nxt;
  logic             cs_n_q, cs_n_nxt;
  logic [BITS-1:0]  rx_data_q, rx_data_nxt;
  logic             rx_valid_q, rx_valid_nxt;
  logic             done_q, done_nxt;

  always_comb begin
    state_nxt    = state_q;
    tx_left_nxt  = tx_left_q;
    rx_left_nxt  = rx_left_q;
    cs_n_nxt     = cs_n_q;
    rx_data_nxt  = rx_data_q;
    rx_valid_nxt = 1'b0;
    done_nxt     = 1'b0;
    tx_ready     = 1'b0;
    sh_load      = 1'b0;
    sh_byte      = '0;
    sh_abort     = !enable;
    if (!enable) begin
      state_nxt = ST_IDLE;
      cs_n_nxt  = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          cs_n_nxt = 1'b1;
          if (start) begin
            state_nxt   = ST_LEAD;
            cs_n_nxt    = 1'b0;
            tx_left_nxt = tx_len;
            rx_left_nxt = rx_len;
          end
        end
        ST_LEAD: begin
          if (tx_left_q != '0)      state_nxt = ST_TX_REQ;
          else if (rx_left_q != '0) state_nxt = ST_RX_GO;
          else                      state_nxt = ST_FINISH;
        end
        ST_TX_REQ: begin
          tx_ready = 1'b1;
          if (tx_valid) begin
            sh_load   = 1'b1;
            sh_byte   = tx_data;
            state_nxt = ST_TX_RUN;
          end
        end
        ST_TX_RUN: begin
          if (byte_done) begin
            tx_left_nxt = tx_left_q - ONE;
            if (tx_left_q != ONE)     state_nxt = ST_TX_REQ;
            else if (rx_left_q != '0) state_nxt = ST_RX_GO;
            else                      state_nxt = ST_FINISH;
          end
        end
        ST_RX_GO: begin
          sh_load   = 1'b1;
          sh_byte   = '0;
          state_nxt = ST_RX_RUN;
        end
        ST_RX_RUN: begin
          if (byte_done) begin
            rx_valid_nxt = 1'b1;
            rx_data_nxt  = rx_byte;
            rx_left_nxt  = rx_left_q - ONE;
            state_nxt    = (rx_left_q != ONE) ? ST_RX_GO : ST_FINISH;
          end
        end
        ST_FINISH: begin
          cs_n_nxt  = 1'b1;
          done_nxt  = 1'b1;
          state_nxt = ST_IDLE;
        end
        default: begin
          state_nxt = ST_IDLE;
          cs_n_nxt  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      tx_left_q  <= '0;
      rx_left_q  <= '0;
      cs_n_q     <= 1'b1;
      rx_data_q  <= '0;
      rx_valid_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q    <= state_nxt;
      tx_left_q  <= tx_left_nxt;
      rx_left_q  <= rx_left_nxt;
      cs_n_q     <= cs_n_nxt;
      rx_data_q  <= rx_data_nxt;
      rx_valid_q <= rx_valid_nxt;
      done_q     <= done_nxt;
    end
  end

  assign cs_n     = cs_n_q;
  assign rx_data  = rx_data_q;
  assign rx_valid = rx_valid_q;
  assign done     = done_q;

  // R2
  done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (cs_n_q && $past(!cs_n_q)));

  // R9
  disabled_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> cs_n_q);

  // R10
  rx_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_q |-> !cs_n_q);

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && enable) |=> (state_q != ST_LEAD));
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine #(
  parameter int LEN_W     = 8,
  parameter int BITS      = 8,
  parameter int SYS_W     = 32,
  parameter int DIV_W     = 7,
  parameter int TARGET_HZ = 8_000_000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             start,
  input  logic [LEN_W-1:0] tx_len,
  input  logic [LEN_W-1:0] rx_len,
  input  logic [SYS_W-1:0] sys_hz,
  input  logic [BITS-1:0]  tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             cs_n,
  output logic [BITS-1:0]  rx_data,
  output logic             rx_valid,
  output logic             done
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [DIV_W-1:0] div;
  logic             tick;
  logic             sh_active;
  logic             sh_load;
  logic             sh_abort;
  logic [BITS-1:0]  sh_byte;
  logic             byte_done;
  logic [BITS-1:0]  rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spi_rate_calc #(.SYS_W(SYS_W), .DIV_W(DIV_W), .TARGET_HZ(TARGET_HZ)) i_rate (
    .clk(clk), .rst_n(rst_int_n), .sys_hz(sys_hz), .div(div)
  );

  spi_half_tick #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst_n(rst_int_n), .run(sh_active), .div(div), .tick(tick)
  );

  spi_byte_shifter #(.BITS(BITS)) i_shift (
    .clk(clk), .rst_n(rst_int_n), .load(sh_load), .abort(sh_abort),
    .load_byte(sh_byte), .tick(tick), .miso(miso), .active(sh_active),
    .sclk(sclk), .mosi(mosi), .byte_done(byte_done), .rx_byte(rx_byte)
  );

  spi_xfer_ctrl #(.LEN_W(LEN_W), .BITS(BITS)) i_ctrl (
    .clk(clk), .rst_n(rst_int_n), .enable(enable), .start(start),
    .tx_len(tx_len), .rx_len(rx_len), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .byte_done(byte_done), .rx_byte(rx_byte),
    .sh_load(sh_load), .sh_byte(sh_byte), .sh_abort(sh_abort), .cs_n(cs_n),
    .rx_data(rx_data), .rx_valid(rx_valid), .done(done)
  );

  // R6
  idle_mosi_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    cs_n |-> !mosi);

  // R3
  tx_req_in_window_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_ready |-> (!cs_n && !sh_active));
endmodule

// File: tb/test_spi_xfer_engine.sv
module test_spi_xfer_engine;
  logic        clk, rst_n, enable, start;
  logic [7:0]  tx_len, rx_len, tx_data, rx_data;
  logic [31:0] sys_hz;
  logic        tx_valid, tx_ready, miso, sclk, mosi, cs_n, rx_valid, done;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic [7:0] tx_q[$];
  logic [7:0] exp_mosi[$];
  logic [7:0] exp_rx[$];
  int  cs_falls = 0, done_cnt = 0, idle_mosi_err = 0, hi_run = 0, last_hi = 0;
  bit  tx_pend = 0;
  logic cs_prev = 1'b1, sclk_prev = 1'b0;
  int  s_idx = 0, s_bits = 0;
  logic [7:0] s_cur = 8'h00, s_cap = 8'h00;

  spi_xfer_engine i_spi_xfer_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start(start),
    .tx_len(tx_len), .rx_len(rx_len), .sys_hz(sys_hz), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .miso(miso), .sclk(sclk),
    .mosi(mosi), .cs_n(cs_n), .rx_data(rx_data), .rx_valid(rx_valid), .done(done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [7:0] slave_byte(input int i);
    return 8'hA5 ^ 8'(i * 37);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Peripheral model, mode 0: MISO changes on falling SCLK, MOSI captured on rising.
  always @(cs_n or sclk) begin
    if (cs_prev && !cs_n) begin
      s_idx = 0; s_bits = 0; s_cur = slave_byte(0); miso = s_cur[7];
    end else if (!cs_n && !sclk_prev && sclk) begin
      s_cap = {s_cap[6:0], mosi};
      s_bits++;
      if (s_bits == 8) begin
        s_bits = 0;
        if (exp_mosi.size() == 0) check(1'b0, "R3 extra MOSI byte", s_cap, -1);
        else begin
          logic [7:0] e;
          e = exp_mosi.pop_front();
          check(s_cap == e, "R3/R4 MOSI byte", s_cap, e);
        end
        s_idx++;
        s_cur = slave_byte(s_idx);
      end
    end else if (!cs_n && sclk_prev && !sclk) begin
      miso = s_cur[7 - s_bits];
    end
    cs_prev = cs_n;
    sclk_prev = sclk;
  end

  // Stream driver and monitor, both away from the active edge.
  always @(negedge clk) begin
    cycles++;
    if (tx_pend && tx_q.size() > 0) void'(tx_q.pop_front());
    tx_valid = (tx_q.size() > 0);
    tx_data  = (tx_q.size() > 0) ? tx_q[0] : 8'h00;
    tx_pend  = tx_ready && tx_valid;
    if (rst_n) begin
      if (cs_n && mosi) idle_mosi_err++;
      if (done) done_cnt++;
      if (sclk) hi_run++;
      else if (hi_run != 0) begin last_hi = hi_run; hi_run = 0; end
      if (rx_valid) begin
        if (exp_rx.size() == 0) check(1'b0, "R10 unexpected rx_valid", rx_data, -1);
        else begin
          logic [7:0] e;
          e = exp_rx.pop_front();
          check(rx_data == e, "R4 rx byte", rx_data, e);
        end
      end
    end
  end

  always @(negedge cs_n) cs_falls++;

  always @(negedge clk) begin
    if (cycles > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic run_xact(input logic [31:0] hz, input int ntx, input int nrx,
                          input int exp_half, input bit extra_start);
    int f0, d0, t;
    logic last_cs;
    sys_hz = hz;
    repeat (4) @(negedge clk);
    for (int i = 0; i < ntx; i++) begin
      logic [7:0] b;
      b = 8'(i * 29 + 3) ^ 8'h3C;
      tx_q.push_back(b);
      exp_mosi.push_back(b);
    end
    for (int k = 0; k < nrx; k++) begin
      exp_mosi.push_back(8'h00);
      exp_rx.push_back(slave_byte(ntx + k));
    end
    tx_len = 8'(ntx); rx_len = 8'(nrx);
    f0 = cs_falls; d0 = done_cnt;
    start = 1'b1; @(negedge clk); start = 1'b0;
    if (extra_start) begin
      repeat (10) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    t = 0;
    last_cs = cs_n;
    while (!done && t < 60000) begin
      last_cs = cs_n;
      @(negedge clk);
      t++;
    end
    check(done == 1'b1, "R2 done seen", done, 1);
    check(cs_n == 1'b1 && last_cs == 1'b0, "R2 done with cs_n just released", cs_n, 1);
    @(negedge clk);
    check(done == 1'b0, "R2 done one cycle", done, 0);
    repeat (30) @(negedge clk);
    check(cs_falls == f0 + 1, "R2/R7/R8 single cs window", cs_falls - f0, 1);
    check(done_cnt == d0 + 1, "R2/R8 single done", done_cnt - d0, 1);
    check(exp_mosi.size() == 0, "R3/R4 all MOSI bytes sent", exp_mosi.size(), 0);
    check(exp_rx.size() == 0, "R4 all rx bytes delivered", exp_rx.size(), 0);
    check(tx_q.size() == 0, "R3 all tx bytes taken", tx_q.size(), 0);
    if (exp_half != 0) check(last_hi == exp_half, "R1 SCLK half period", last_hi, exp_half);
  endtask

  initial begin
    rst_n = 1'b0; enable = 1'b1; start = 1'b0; tx_len = '0; rx_len = '0;
    sys_hz = 32'd32_000_000; miso = 1'b0; tx_valid = 1'b0; tx_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R2 R5 R6 reset state
    check(cs_n == 1'b1, "R2 reset cs_n", cs_n, 1);
    check(sclk == 1'b0, "R5 reset sclk", sclk, 0);
    check(mosi == 1'b0, "R6 reset mosi", mosi, 0);
    check(done == 1'b0 && rx_valid == 1'b0, "R10 reset outputs", rx_valid, 0);

    run_xact(32'd32_000_000, 4, 2, 2, 1'b0);            // R3 R4 R1
    run_xact(32'd16_000_000, 1, 3, 1, 1'b0);            // R1 q=1
    run_xact(32'd48_000_000, 0, 2, 3, 1'b0);            // R7 write skipped
    run_xact(32'd8_000_000, 2, 0, 1, 1'b0);             // R7 read skipped, q=0
    run_xact(32'd32_000_000, 0, 0, 0, 1'b0);            // R7 both zero
    run_xact(32'd2_032_000_000, 1, 0, 127, 1'b0);       // R1 below clamp
    run_xact(32'd4_000_000_000, 0, 1, 128, 1'b0);       // R1 clamp
    run_xact(32'd32_000_000, 3, 3, 2, 1'b1);            // R8 start while busy

    // R9 abort and refusal while disabled
    sys_hz = 32'd48_000_000;
    repeat (4) @(negedge clk);
    tx_len = 8'd3; rx_len = 8'd2;
    for (int i = 0; i < 3; i++) tx_q.push_back(8'hF0);
    start = 1'b1; @(negedge clk); start = 1'b0;
    repeat (40) @(negedge clk);
    check(cs_n == 1'b0, "R9 window open before disable", cs_n, 0);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    check(cs_n == 1'b1, "R9 cs_n high after disable", cs_n, 1);
    tx_q.delete(); exp_mosi.delete(); exp_rx.delete();
    begin
      int f0, d0;
      f0 = cs_falls; d0 = done_cnt;
      start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      check(cs_falls == f0 && cs_n == 1'b1, "R9 start ignored when disabled", cs_falls - f0, 0);
      check(done_cnt == d0, "R9 no done when disabled", done_cnt - d0, 0);
    end
    enable = 1'b1;
    repeat (4) @(negedge clk);
    run_xact(32'd32_000_000, 2, 2, 2, 1'b0);            // recovery

    check(idle_mosi_err == 0, "R6 mosi low while cs_n high", idle_mosi_err, 0);
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule